// File: doc/BRIEF.md
# Supply-Drop Interrupt Filter

This block is the digital back end of a supply-voltage monitor. An analog comparator outside the block drives `sense_ok_async` high while the supply is above its threshold and low when it sags. That signal is asynchronous. The block brings it into the core clock domain through a two-flop synchronizer. A free-running divider then produces a sampling strobe, and the sampled value passes through a two-sample agreement filter. The clock used here keeps running while the processor sits in wait mode, so the monitor works while the core is halted.

When the filtered level falls, the block sets a sticky drop flag. If the flag was clear, it also raises a request. Software clears the flag with a write strobe. Until then, further drops produce no request. A separate enable bit masks the request. The request is then merged with the watchdog-underflow and oscillator-event requests into one registered non-maskable interrupt line. Turning the monitor off drives the filtered level high and clears the flag.

Top module: `vdrop_nmi_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `filt_level` is 1, `drop_flag` is 0 and `nmi_req` is 0.
- R2: A free-running counter advances once per clock from reset. A sampling strobe occurs on each edge where (edges since reset) mod P equals P-1. P is 8, 16, 32 or 64 for `rate_sel` = 00, 01, 10 or 11.
- R3: `sense_ok_async` passes through two flops before it is sampled.
- R4: `filt_level` takes a new value only on a strobe whose sample equals the sample from the previous strobe. A pulse shorter than one sample period never changes it.
- R5: With `det_en` = 0, `filt_level` is 1 and `drop_flag` is 0 one cycle later, and the filter's stored sample is held at 1.
- R6: A 1-to-0 change of `filt_level` sets `drop_flag` on the same edge. If the flag was 0 before that edge, it also produces a voltage-drop request.
- R7: While `drop_flag` is 1, a further fall of `filt_level` gives no request. The flag returns to 0 only on a `flag_clr_wr` pulse or when `det_en` = 0. A fall on the same edge as a clear wins.
- R8: A voltage-drop request reaches `nmi_req` only if `irq_en` is 1. The flag is set either way.
- R9: `nmi_req` is a registered OR of the gated voltage-drop request, `wdt_uflow` and `osc_evt`, and it is high on the cycle after its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, active in wait mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_ok_async | input | 1 | Raw comparator output, 1 = supply good |
| det_en | input | 1 | Monitor enable |
| irq_en | input | 1 | Voltage-drop interrupt enable |
| rate_sel | input | 2 | Sampling-divider tap select |
| flag_clr_wr | input | 1 | Write strobe that clears the drop flag |
| wdt_uflow | input | 1 | Watchdog underflow request |
| osc_evt | input | 1 | Oscillation stop/restart request |
| filt_level | output | 1 | Filtered supply-good level |
| drop_flag | output | 1 | Sticky voltage-drop flag |
| nmi_req | output | 1 | Combined non-maskable interrupt pulse |

## Verification
The bench sends in glitches shorter than one sample period at the slowest tap. A filter that acted on a single sample would let `filt_level` fall on such a glitch. It repeats drops while the flag is still set. A design that did not block on the flag would pulse `nmi_req` a second time. It changes `rate_sel` in mid-run and lines its model up against the strobe phase. A wrong tap or a counter that restarts would shift when the filter output falls. It also times a clear strobe against a fall and disables the monitor while a drop is in progress. Getting the priority wrong would lose a detection, and failing to force the level high would leave a stale low level behind.

// File: rtl/vdrop_nmi_filter.sv
module vdrop_nmi_filter #(
  parameter int BASE_LOG2 = 3,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_ok_async,
  input  logic             det_en,
  input  logic             irq_en,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             flag_clr_wr,
  input  logic             wdt_uflow,
  input  logic             osc_evt,
  output logic             filt_level,
  output logic             drop_flag,
  output logic             nmi_req
);
  localparam int NTAPS = 1 << SEL_W;
  localparam int CW    = BASE_LOG2 + NTAPS - 1;

  logic [CW-1:0]    cnt;
  logic [NTAPS-1:0] tap;
  logic             sync1, sync2, smp;
  logic             tick, det_in, lev_nxt, fall, vd_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    assign tap[i] = &cnt[BASE_LOG2-1+i:0];
  end

  assign tick = tap[rate_sel];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync2, sync1} <= 2'b11;
    else        {sync2, sync1} <= {sync1, sense_ok_async};

  assign det_in = det_en ? sync2 : 1'b1;

  always_comb begin
    lev_nxt = filt_level;
    if (!det_en)                     lev_nxt = 1'b1;
    else if (tick && det_in == smp)  lev_nxt = det_in;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp        <= 1'b1;
      filt_level <= 1'b1;
    end else begin
      filt_level <= lev_nxt;
      if (!det_en)   smp <= 1'b1;
      else if (tick) smp <= det_in;
    end

  assign fall   = filt_level & ~lev_nxt;
  assign vd_req = fall & ~drop_flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           drop_flag <= 1'b0;
    else if (!det_en)     drop_flag <= 1'b0;
    else if (fall)        drop_flag <= 1'b1;
    else if (flag_clr_wr) drop_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nmi_req <= 1'b0;
    else        nmi_req <= (vd_req & irq_en) | wdt_uflow | osc_evt;
endmodule

module vdrop_nmi_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic det_en,
  input logic irq_en,
  input logic flag_clr_wr,
  input logic wdt_uflow,
  input logic osc_evt,
  input logic filt_level,
  input logic drop_flag,
  input logic nmi_req
);
  p_off_level_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> filt_level);
  p_off_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !drop_flag);
  p_fall_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_level) |-> drop_flag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag && det_en && !flag_clr_wr |=> drop_flag);
  p_nmi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(wdt_uflow) || $past(osc_evt) || ($fell(filt_level) && $past(irq_en)));
  p_wdt_to_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_uflow || osc_evt |=> nmi_req);
endmodule

bind vdrop_nmi_filter vdrop_nmi_filter_chk u_chk (.*);

// File: tb/sim_vdrop_nmi_filter.sv
module sim_vdrop_nmi_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic sense = 1, det_en = 0, irq_en = 0, clr = 0, wdt = 0, osc = 0;
  logic [1:0] sel = 0;
  logic filt_level, drop_flag, nmi_req;

  int nchk = 0, nfail = 0, cycles = 0;

  vdrop_nmi_filter u0 (
    .clk(clk), .rst_n(rst_n), .sense_ok_async(sense), .det_en(det_en),
    .irq_en(irq_en), .rate_sel(sel), .flag_clr_wr(clr), .wdt_uflow(wdt),
    .osc_evt(osc), .filt_level(filt_level), .drop_flag(drop_flag), .nmi_req(nmi_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int period_of(input logic [1:0] s);
    return 8 << s;
  endfunction

  // reference model built from the requirements (R2 strobe, R3 sync, R4 filter)
  logic m_s1, m_s2, m_smp, m_lev, m_flag, m_nmi;
  int   m_cyc;
  bit   model_on = 0;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_smp = 1; m_lev = 1; m_flag = 0; m_nmi = 0; m_cyc = 0;
    end else begin
      bit tk, din, nlev, nsmp, fl;
      tk   = (m_cyc % period_of(sel)) == period_of(sel) - 1;
      din  = det_en ? m_s2 : 1'b1;
      nlev = m_lev; nsmp = m_smp;
      if (!det_en) begin nlev = 1; nsmp = 1; end
      else if (tk) begin nsmp = din; if (din == m_smp) nlev = din; end
      fl    = m_lev && !nlev;
      m_nmi = (fl && !m_flag && irq_en) || wdt || osc;
      if (!det_en)  m_flag = 0;
      else if (fl)  m_flag = 1;
      else if (clr) m_flag = 0;
      m_lev = nlev; m_smp = nsmp;
      m_s2 = m_s1; m_s1 = sense;
      m_cyc++;
    end
  end

  always @(negedge clk) if (model_on && rst_n) begin
    chk(filt_level == m_lev,  "R2,R3,R4 filt_level", filt_level, m_lev);
    chk(drop_flag  == m_flag, "R6,R7 drop_flag",    drop_flag,  m_flag);
    chk(nmi_req    == m_nmi,  "R8,R9 nmi_req",      nmi_req,    m_nmi);
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cycles, 200000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int pulses;
  always @(negedge clk) if (nmi_req) pulses++;

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    chk(filt_level == 1 && drop_flag == 0 && nmi_req == 0, "R1 reset state",
        {filt_level, drop_flag, nmi_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(filt_level == 1 && drop_flag == 0 && nmi_req == 0, "R1 after release",
        {filt_level, drop_flag, nmi_req}, 3'b100);
    model_on = 1;

    // R4: glitch shorter than a sample period at the slowest tap
    det_en = 1; irq_en = 1; sel = 2'b11;
    idle(200);
    sense = 0; idle(20); sense = 1;
    idle(300);
    chk(filt_level == 1, "R4 glitch rejected", filt_level, 1);

    // R6: first drop gives one request
    pulses = 0;
    sense = 0; sel = 2'b00; idle(60);
    chk(drop_flag == 1, "R6 flag set", drop_flag, 1);
    chk(pulses == 1, "R6 one request", pulses, 1);
    // R7: repeat drop while flag set gives nothing
    sense = 1; idle(60); sense = 0; idle(60);
    chk(pulses == 1, "R7 blocked while flagged", pulses, 1);
    chk(drop_flag == 1, "R7 flag sticky", drop_flag, 1);
    clr = 1; @(negedge clk); clr = 0;
    chk(drop_flag == 0, "R7 clear strobe", drop_flag, 0);
    sense = 1; idle(60); sense = 0; idle(60);
    chk(pulses == 2, "R7 new request after clear", pulses, 2);

    // R5: disable forces level high and flag low
    det_en = 0; @(negedge clk);
    chk(filt_level == 1 && drop_flag == 0, "R5 disabled", {filt_level, drop_flag}, 2'b10);
    idle(5); det_en = 1; idle(60);
    chk(drop_flag == 1, "R5 re-enable redetects", drop_flag, 1);

    // R8: masked request still sets the flag
    clr = 1; @(negedge clk); clr = 0;
    sense = 1; idle(60);
    irq_en = 0; pulses = 0;
    sense = 0; idle(60);
    chk(pulses == 0 && drop_flag == 1, "R8 masked", pulses, 0);

    // R9: watchdog and oscillator events
    wdt = 1; @(negedge clk); wdt = 0;
    chk(nmi_req == 1, "R9 watchdog", nmi_req, 1);
    @(negedge clk);
    chk(nmi_req == 0, "R9 single pulse", nmi_req, 0);
    osc = 1; @(negedge clk); osc = 0;
    chk(nmi_req == 1, "R9 oscillator", nmi_req, 1);

    // constrained random phase, checked against the model every cycle
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      len = 10 + ($urandom % 250);
      sense = $urandom % 2;
      if ($urandom % 8 == 0) sel = $urandom % 4;
      if ($urandom % 10 == 0) det_en = ~det_en;
      if ($urandom % 6 == 0) irq_en = ~irq_en;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        clr = ($urandom % 97) == 0;
        wdt = ($urandom % 151) == 0;
        osc = ($urandom % 173) == 0;
        if ($urandom % 41 == 0) sense = ~sense;
      end
    end
    clr = 0; wdt = 0; osc = 0;
    idle(5);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule